// File: doc/BRIEF.md
# Configuration Start-up Sequencer

This block closes out device configuration. Once the configuration length counter reports a match, the sequencer walks a short chain of timing stages, numbered 0 to 4. It advances one stage for each pulse of a selectable sequence clock. Three end-of-configuration events are each tied to a stage that the user chooses:

- DONE goes high.
- The global output tri-state (GTS) is released.
- The global set/reset (GSR) is released.

When the last stage is reached the block raises FINISHED. FINISHED is what permits readback and boundary-scan operations. A device that gets too few sequence pulses can therefore show DONE high and never finish.

The block runs on one fast system clock. Each edge of the configuration clock and of the user start-up clock reaches it as a one-cycle step strobe. GTS and GSR can each also be forced active from a user net. Each of these user paths has its own enable and its own polarity option. All option bits are captured at the match, so the sequence that follows is not affected by later changes to them.

Top module: `cfg_startup_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `done` and `finished` low and `gts` and `gsr` high (active). It also discards any sequence in progress.
- R2: The sequence starts only at an edge where `cfg_step` and `len_match` are both high while the block is idle. That edge puts the sequence at stage 0. Steps without a match leave the block idle, and a match without `cfg_step` does not start it.
- R3: After the start, each step of the selected clock advances the sequence by exactly one stage. The selected clock is `cfg_step` when `opt_clk_sel` is 0 and `usr_step` when it is 1. The other strobe has no effect.
- R4: `done` is high exactly while the sequence is running and its stage is greater than or equal to `opt_done_stage`. Once high, `done` stays high until reset.
- R5: The stage part of `gts` is released (low) once the stage is greater than or equal to `opt_gts_stage`. The stage part of `gsr` is released the same way against `opt_gsr_stage`.
- R6: When the user path of GTS is enabled, `gts` is also held active whenever `usr_gts` XOR the invert option is 1. GSR has a separate user path that works the same way with `usr_gsr`. This user term acts combinationally, without waiting for a clock edge. When the path is disabled, the user net has no effect.
- R7: `finished` rises at the edge that brings the sequence to stage 4. It then holds, and all further steps are ignored until reset.
- R8: If the steps stop before stage 4, `finished` stays low even when `done` is already high. A stage select above 4 is never reached, so its event never occurs.
- R9: All option inputs are captured at the starting edge. Changes to them afterwards do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous configuration reset, active high |
| cfg_step | input | 1 | One-cycle strobe per configuration clock edge |
| usr_step | input | 1 | One-cycle strobe per user start-up clock edge |
| len_match | input | 1 | Length count equals the programmed value |
| opt_clk_sel | input | 1 | Sequence clock: 0 configuration, 1 user |
| opt_done_stage | input | 3 | Stage at which DONE goes high |
| opt_gts_stage | input | 3 | Stage at which GTS is released |
| opt_gsr_stage | input | 3 | Stage at which GSR is released |
| opt_gts_usr_en | input | 1 | Enable the user-net path into GTS |
| opt_gts_usr_inv | input | 1 | Invert the GTS user net |
| opt_gsr_usr_en | input | 1 | Enable the user-net path into GSR |
| opt_gsr_usr_inv | input | 1 | Invert the GSR user net |
| usr_gts | input | 1 | User net that can force GTS active |
| usr_gsr | input | 1 | User net that can force GSR active |
| done | output | 1 | Configuration done indication |
| gts | output | 1 | Global output tri-state, active high |
| gsr | output | 1 | Global set/reset, active high |
| finished | output | 1 | Sequence complete; readback and boundary scan allowed |

## Verification
Every stage-driven result (`done`, the stage part of `gts`/`gsr`, `finished`) changes at the clock edge that takes the step. These outputs come straight from the stage register, so they are due one edge after the strobe is driven. The bench drives strobes at a falling edge and samples at the next falling edge. The user-net terms of `gts` and `gsr` need no edge at all. The bench checks them shortly after changing the user net, with no clock edge in between. The sticky and step-only behaviour is also watched on every edge by the bound checker.

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
  parameter int LAST_STAGE = 4,
  localparam int SW = $clog2(LAST_STAGE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_step,
  input  logic          usr_step,
  input  logic          len_match,
  input  logic          opt_clk_sel,
  input  logic [SW-1:0] opt_done_stage,
  input  logic [SW-1:0] opt_gts_stage,
  input  logic [SW-1:0] opt_gsr_stage,
  input  logic          opt_gts_usr_en,
  input  logic          opt_gts_usr_inv,
  input  logic          opt_gsr_usr_en,
  input  logic          opt_gsr_usr_inv,
  input  logic          usr_gts,
  input  logic          usr_gsr,
  output logic          done,
  output logic          gts,
  output logic          gsr,
  output logic          finished
);
  localparam logic [SW-1:0] LAST = SW'(LAST_STAGE);

  logic          run;
  logic [SW-1:0] stg;
  logic          clk_sel_q;
  logic [SW-1:0] done_q, gts_q, gsr_q;
  logic          gts_en_q, gts_inv_q, gsr_en_q, gsr_inv_q;

  wire adv = clk_sel_q ? usr_step : cfg_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      stg       <= '0;
      clk_sel_q <= 1'b0;
      done_q    <= '0;
      gts_q     <= '0;
      gsr_q     <= '0;
      gts_en_q  <= 1'b0;
      gts_inv_q <= 1'b0;
      gsr_en_q  <= 1'b0;
      gsr_inv_q <= 1'b0;
    end else if (!run) begin
      if (cfg_step && len_match) begin
        run       <= 1'b1;
        stg       <= '0;
        clk_sel_q <= opt_clk_sel;
        done_q    <= opt_done_stage;
        gts_q     <= opt_gts_stage;
        gsr_q     <= opt_gsr_stage;
        gts_en_q  <= opt_gts_usr_en;
        gts_inv_q <= opt_gts_usr_inv;
        gsr_en_q  <= opt_gsr_usr_en;
        gsr_inv_q <= opt_gsr_usr_inv;
      end
    end else if (adv && stg != LAST) begin
      stg <= stg + SW'(1);
    end
  end

  assign done     = run && (stg >= done_q);
  assign finished = run && (stg == LAST);
  assign gts = !(run && (stg >= gts_q)) || (gts_en_q && (usr_gts ^ gts_inv_q));
  assign gsr = !(run && (stg >= gsr_q)) || (gsr_en_q && (usr_gsr ^ gsr_inv_q));
endmodule

// File: rtl/cfg_startup_seq_chk.sv
module cfg_startup_seq_chk (
  input logic clk,
  input logic rst,
  input logic cfg_step,
  input logic usr_step,
  input logic done,
  input logic finished
);
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_finished_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    finished |=> finished && done == $past(done));

  assert_done_needs_step_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cfg_step || usr_step));

  assert_finished_needs_step_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(finished) |-> $past(cfg_step || usr_step));

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !finished && !done);
endmodule

bind cfg_startup_seq cfg_startup_seq_chk u_chk (
  .clk(clk), .rst(rst), .cfg_step(cfg_step), .usr_step(usr_step),
  .done(done), .finished(finished)
);

// File: tb/cfg_startup_seq_tb.sv
module cfg_startup_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cfg_step, usr_step, len_match, opt_clk_sel;
  logic [2:0] opt_done_stage, opt_gts_stage, opt_gsr_stage;
  logic opt_gts_usr_en, opt_gts_usr_inv, opt_gsr_usr_en, opt_gsr_usr_inv;
  logic usr_gts, usr_gsr;
  logic done, gts, gsr, finished;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  cfg_startup_seq u_dut (
    .clk(clk), .rst(rst), .cfg_step(cfg_step), .usr_step(usr_step),
    .len_match(len_match), .opt_clk_sel(opt_clk_sel),
    .opt_done_stage(opt_done_stage), .opt_gts_stage(opt_gts_stage),
    .opt_gsr_stage(opt_gsr_stage), .opt_gts_usr_en(opt_gts_usr_en),
    .opt_gts_usr_inv(opt_gts_usr_inv), .opt_gsr_usr_en(opt_gsr_usr_en),
    .opt_gsr_usr_inv(opt_gsr_usr_inv), .usr_gts(usr_gts), .usr_gsr(usr_gsr),
    .done(done), .gts(gts), .gsr(gsr), .finished(finished)
  );

  // {cfg_step, usr_step, len_match, usr_gts, usr_gsr, exp done, gts, gsr, finished}
  localparam logic [8:0] VEC [10] = '{
    9'b100_00_0110,   // step without match: idle
    9'b001_00_0110,   // match without step: idle
    9'b101_00_0110,   // start, stage 0
    9'b010_00_0110,   // user strobe ignored
    9'b100_00_1110,   // stage 1: done
    9'b100_00_1010,   // stage 2: gts released
    9'b000_00_1010,   // no step
    9'b100_00_1000,   // stage 3: gsr released
    9'b100_00_1001,   // stage 4: finished
    9'b100_11_1001    // extra step, disabled user nets
  };

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk4(input string req, input logic [3:0] exp);
    chk({req, " done"}, done, exp[3]);
    chk({req, " gts"}, gts, exp[2]);
    chk({req, " gsr"}, gsr, exp[1]);
    chk({req, " finished"}, finished, exp[0]);
  endtask

  task automatic cyc(input logic c, input logic u, input logic m);
    cfg_step = c; usr_step = u; len_match = m;
    @(posedge clk);
    @(negedge clk);
    cfg_step = 1'b0; usr_step = 1'b0; len_match = 1'b0;
  endtask

  task automatic set_opts(input logic cs, input logic [2:0] d, input logic [2:0] t,
                          input logic [2:0] s, input logic [3:0] usr);
    opt_clk_sel = cs; opt_done_stage = d; opt_gts_stage = t; opt_gsr_stage = s;
    {opt_gts_usr_en, opt_gts_usr_inv, opt_gsr_usr_en, opt_gsr_usr_inv} = usr;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst = 1'b1; cfg_step = 0; usr_step = 0; len_match = 0;
    usr_gts = 0; usr_gsr = 0;
    set_opts(1'b0, 3'd1, 3'd2, 3'd3, 4'b0000);
    @(negedge clk);
    do_reset();
    chk4("R1 reset", 4'b0110);

    // vector table: R2 R3 R4 R5 R7
    for (int i = 0; i < 10; i++) begin
      usr_gts = VEC[i][5]; usr_gsr = VEC[i][4];
      cyc(VEC[i][8], VEC[i][7], VEC[i][6]);
      chk4($sformatf("R2/R3/R4/R5/R7 vec%0d", i), VEC[i][3:0]);
    end
    usr_gts = 0; usr_gsr = 0;

    // mid-sequence reset (R1)
    do_reset();
    set_opts(1'b0, 3'd0, 3'd0, 3'd0, 4'b0000);
    cyc(1, 0, 1); cyc(1, 0, 0);
    do_reset();
    chk4("R1 mid-sequence reset", 4'b0110);

    // user clock select, done at stage 0, clock stops early (R3 R4 R8)
    set_opts(1'b1, 3'd0, 3'd4, 3'd4, 4'b0000);
    cyc(1, 0, 1);
    chk4("R4 done at stage0", 4'b1110);
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
    chk("R3 cfg strobe ignored under user clock", finished, 1'b0);
    cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    chk4("R8 stopped at stage3 not finished", 4'b1110);
    cyc(0, 1, 0);
    chk4("R3 user strobe reaches stage4", 4'b1001);

    // user override paths (R6), combinational
    do_reset();
    set_opts(1'b0, 3'd0, 3'd0, 3'd0, 4'b1011);
    usr_gts = 0; usr_gsr = 0;
    cyc(1, 0, 1);
    #1;
    chk("R6 gts user low", gts, 1'b0);
    chk("R6 gsr inverted user low", gsr, 1'b1);
    usr_gts = 1; usr_gsr = 1;
    #1;
    chk("R6 gts user high", gts, 1'b1);
    chk("R6 gsr inverted user high", gsr, 1'b0);
    usr_gts = 0;
    #1;
    chk("R6 gts follows user net", gts, 1'b0);

    // options captured at start (R9), unreachable select (R8)
    do_reset();
    usr_gts = 0; usr_gsr = 0;
    set_opts(1'b0, 3'd4, 3'd1, 3'd7, 4'b0000);
    cyc(1, 0, 1);
    set_opts(1'b1, 3'd0, 3'd0, 3'd0, 4'b1010);
    usr_gts = 1; usr_gsr = 1;
    cyc(1, 0, 0);
    chk4("R9 late option change ignored", 4'b0010);
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
    chk4("R8 gsr select 7 never released", 4'b1011);
    cyc(1, 0, 1);
    chk4("R7 steps ignored after finish", 4'b1011);

    report();
  end
endmodule